// File: doc/BRIEF.md
# SPI Flash Transfer Engine

This block is the data-moving core of a serial NOR flash controller. A host fills a 64-byte buffer through a 32-bit register port, programs how many bits to move, and writes a start bit. The engine then drives one active-low chip select and a mode-0 serial clock. It shifts the buffer out most-significant bit first and, when full duplex is enabled, writes each received bit back into the buffer position it came from. At the end it raises a done flag. Longer messages are sent as a series of chunks of at most 64 bytes. Chip select can stay low from one chunk to the next, so the chunks form one flash command.

Serial clock timing comes from two strobe inputs, one per clock edge, produced by a divider outside the block. The engine changes the serial clock only when a strobe is present and matches the current clock level. The register port is a plain control port. Every write is taken in the cycle it is presented, so there is no back-pressure. Read data is combinational from the address.

Top module: `spifc_engine`

## Requirements
- R1: The buffer is mapped as 16 words at byte addresses 0x40 to 0x7C. Byte n is held in bits [8*(n%4)+7 : 8*(n%4)] of the word at address 0x40+4*(n/4). A write to a word updates its four bytes, and a read returns them.
- R2: The field at bits [25:17] of address 0x20 holds the number of bits to transfer, minus one. A transfer produces exactly that many plus one rising serial clock edges.
- R3: Writing a word with bit 18 set to address 0x00 starts a transfer. Bit 18 of address 0x00 reads 1 while the transfer is running and 0 once it has ended.
- R4: Bit 4 of address 0x30 is the done flag. It is set when the last bit has been shifted. Writing that address with bit 4 equal to 0 clears it.
- R5: The serial clock idles low. MOSI changes only after falling edges and holds still while the clock is high. Bits leave each byte MSB first, and MISO is captured at rising edges.
- R6: When bit 0 of address 0x1C is 1, each received bit replaces the transmitted bit at the same buffer position. When it is 0, the buffer is left unchanged by the transfer.
- R7: When bit 30 of address 0x2C is 1 at start, chip select stays low after the transfer. A following transfer then begins with no release. When it is 0, chip select returns high at the end.
- R8: Writing bit 31 of address 0x30 as 1 performs a soft reset. The shifter stops, chip select goes high, the clock goes low, and busy and done clear. Bit 31 always reads back 0.
- R9: A start written while a transfer is running is ignored. The running transfer keeps its bit count.
- R10: Buffer writes from the host are ignored while a transfer runs. Changes to the length, duplex or hold settings during a transfer take effect only at the next start.
- R11: When chip select was high before a start, at least one strobe interval passes between chip select falling and the first rising clock edge.
- R12: After reset, chip select is high, the clock and MOSI are low, and every register and buffer word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Byte address of the register or buffer word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sck_rise_en | input | 1 | Divider strobe allowing a rising serial clock edge |
| sck_fall_en | input | 1 | Divider strobe allowing a falling serial clock edge |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest cases to reach are a second start, a length change and a buffer write that arrive while bits are already moving, and a soft reset that lands in the middle of a transfer with chip select held. The bench makes these cases happen by issuing those writes a fixed number of cycles after the start. It drives the edge strobes itself at a slow, fixed rate, so the bit being shifted at that moment is known. It then compares the clock count and the captured bytes seen by a slave model against the original chunk.

// File: rtl/spifc_pkg.sv
package spifc_pkg;
  // register byte offsets
  localparam int OFS_CMD  = 'h00;
  localparam int OFS_MODE = 'h1C;
  localparam int OFS_LEN  = 'h20;
  localparam int OFS_CS   = 'h2C;
  localparam int OFS_STAT = 'h30;
  // field positions
  localparam int BIT_GO   = 18;
  localparam int BIT_RXEN = 0;
  localparam int LEN_LSB  = 17;
  localparam int BIT_HOLD = 30;
  localparam int BIT_DONE = 4;
  localparam int BIT_SRST = 31;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_SETUP,
    SH_SHIFT
  } sh_state_e;
endpackage

// File: rtl/spifc_buffer.sv
module spifc_buffer #(
  parameter int BUF_BYTES = 64,
  localparam int WORDS  = BUF_BYTES / 4,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int POS_W  = $clog2(BUF_BYTES * 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [WIDX_W-1:0] host_widx,
  input  logic [31:0]       host_wdata,
  input  logic [WIDX_W-1:0] host_ridx,
  output logic [31:0]       host_rdata,
  input  logic [POS_W-1:0]  sh_rpos,
  output logic              sh_rbit,
  input  logic              sh_we,
  input  logic [POS_W-1:0]  sh_wpos,
  input  logic              sh_wbit
);
  logic [7:0] mem [BUF_BYTES];

  // bit position p: byte p/8, bit 7-(p%8), so bits leave MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= '0;
    end else begin
      if (host_we) begin
        for (int b = 0; b < 4; b++)
          mem[{host_widx, 2'(b)}] <= host_wdata[8*b +: 8];
      end
      if (sh_we)
        mem[sh_wpos[POS_W-1:3]][~sh_wpos[2:0]] <= sh_wbit;
    end
  end

  always_comb begin
    for (int b = 0; b < 4; b++)
      host_rdata[8*b +: 8] = mem[{host_ridx, 2'(b)}];
  end

  assign sh_rbit = mem[sh_rpos[POS_W-1:3]][~sh_rpos[2:0]];
endmodule

// File: rtl/spifc_regs.sv
module spifc_regs
  import spifc_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int ADDR_W = $clog2(2 * BUF_BYTES),
  localparam int WIDX_W = $clog2(BUF_BYTES / 4),
  localparam int POS_W  = $clog2(BUF_BYTES * 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              done_set,
  input  logic [31:0]       buf_rdata,
  output logic [WIDX_W-1:0] buf_ridx,
  output logic              buf_we,
  output logic [WIDX_W-1:0] buf_widx,
  output logic              start,
  output logic              soft_rst,
  output logic              rx_en,
  output logic [POS_W-1:0]  len_m1,
  output logic              cs_hold,
  output logic              done
);
  logic is_buf;
  logic hit_cmd, hit_mode, hit_len, hit_cs, hit_stat;

  // buffer occupies the upper half of the address space
  assign is_buf   = addr[ADDR_W-1];
  assign hit_cmd  = !is_buf && (addr == ADDR_W'(OFS_CMD));
  assign hit_mode = !is_buf && (addr == ADDR_W'(OFS_MODE));
  assign hit_len  = !is_buf && (addr == ADDR_W'(OFS_LEN));
  assign hit_cs   = !is_buf && (addr == ADDR_W'(OFS_CS));
  assign hit_stat = !is_buf && (addr == ADDR_W'(OFS_STAT));

  assign start    = wr_en && hit_cmd && wdata[BIT_GO] && !busy;
  assign soft_rst = wr_en && hit_stat && wdata[BIT_SRST];
  assign buf_we   = wr_en && is_buf && !busy;
  assign buf_widx = addr[ADDR_W-2:2];
  assign buf_ridx = addr[ADDR_W-2:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en   <= 1'b0;
      len_m1  <= '0;
      cs_hold <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (wr_en && hit_mode) rx_en   <= wdata[BIT_RXEN];
      if (wr_en && hit_len)  len_m1  <= wdata[LEN_LSB +: POS_W];
      if (wr_en && hit_cs)   cs_hold <= wdata[BIT_HOLD];
      if (soft_rst)
        done <= 1'b0;
      else if (done_set)
        done <= 1'b1;
      else if (wr_en && hit_stat && !wdata[BIT_DONE])
        done <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (is_buf) rdata = buf_rdata;
    else if (hit_cmd)  rdata[BIT_GO]   = busy;
    else if (hit_mode) rdata[BIT_RXEN] = rx_en;
    else if (hit_len)  rdata = 32'(len_m1) << LEN_LSB;
    else if (hit_cs)   rdata[BIT_HOLD] = cs_hold;
    else if (hit_stat) rdata[BIT_DONE] = done;
  end
endmodule

// File: rtl/spifc_shifter.sv
module spifc_shifter
  import spifc_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int POS_W = $clog2(BUF_BYTES * 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start,
  input  logic [POS_W-1:0] len_m1,
  input  logic             rx_en,
  input  logic             cs_hold,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic             miso,
  output logic [POS_W-1:0] rd_pos,
  input  logic             rd_bit,
  output logic             wr_en,
  output logic [POS_W-1:0] wr_pos,
  output logic             wr_bit,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  output logic             busy,
  output logic             done_set
);
  sh_state_e        state;
  logic [POS_W-1:0] cnt, last_q;
  logic             rx_q, hold_q;
  logic             do_rise, do_fall, at_last;

  assign do_rise = (state == SH_SHIFT) && rise_en && !sck;
  assign do_fall = (state == SH_SHIFT) && fall_en && sck;
  assign at_last = (cnt == last_q);

  // next bit to present: bit 0 when idle, otherwise the one after cnt
  assign rd_pos   = (state == SH_IDLE) ? '0 : cnt + 1'b1;
  assign wr_en    = do_rise && rx_q;
  assign wr_pos   = cnt;
  assign wr_bit   = miso;
  assign busy     = (state != SH_IDLE);
  assign done_set = do_fall && at_last && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SH_IDLE;
      cnt    <= '0;
      last_q <= '0;
      rx_q   <= 1'b0;
      hold_q <= 1'b0;
      sck    <= 1'b0;
      cs_n   <= 1'b1;
      mosi   <= 1'b0;
    end else if (soft_rst) begin
      state  <= SH_IDLE;
      cnt    <= '0;
      last_q <= '0;
      rx_q   <= 1'b0;
      hold_q <= 1'b0;
      sck    <= 1'b0;
      cs_n   <= 1'b1;
      mosi   <= 1'b0;
    end else begin
      unique case (state)
        SH_IDLE: begin
          if (start) begin
            cnt    <= '0;
            last_q <= len_m1;
            rx_q   <= rx_en;
            hold_q <= cs_hold;
            mosi   <= rd_bit;
            cs_n   <= 1'b0;
            state  <= cs_n ? SH_SETUP : SH_SHIFT;
          end
        end
        SH_SETUP: begin
          if (rise_en || fall_en) state <= SH_SHIFT;
        end
        SH_SHIFT: begin
          if (do_rise) begin
            sck <= 1'b1;
          end else if (do_fall) begin
            sck <= 1'b0;
            if (at_last) begin
              state <= SH_IDLE;
              cs_n  <= !hold_q;
            end else begin
              cnt  <= cnt + 1'b1;
              mosi <= rd_bit;
            end
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spifc_engine.sv
module spifc_engine
  import spifc_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int ADDR_W = $clog2(2 * BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sck_rise_en,
  input  logic              sck_fall_en,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int WIDX_W = $clog2(BUF_BYTES / 4);
  localparam int POS_W  = $clog2(BUF_BYTES * 8);

  logic              eng_busy, done_flag, done_set;
  logic              start_pulse, srst_pulse;
  logic              cfg_rx, cfg_hold;
  logic [POS_W-1:0]  cfg_len;
  logic              hbuf_we;
  logic [WIDX_W-1:0] hbuf_widx, hbuf_ridx;
  logic [31:0]       hbuf_rdata;
  logic [POS_W-1:0]  sbuf_rpos, sbuf_wpos;
  logic              sbuf_rbit, sbuf_we, sbuf_wbit;

  spifc_regs #(.BUF_BYTES(BUF_BYTES)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .busy     (eng_busy),
    .done_set (done_set),
    .buf_rdata(hbuf_rdata),
    .buf_ridx (hbuf_ridx),
    .buf_we   (hbuf_we),
    .buf_widx (hbuf_widx),
    .start    (start_pulse),
    .soft_rst (srst_pulse),
    .rx_en    (cfg_rx),
    .len_m1   (cfg_len),
    .cs_hold  (cfg_hold),
    .done     (done_flag)
  );

  spifc_buffer #(.BUF_BYTES(BUF_BYTES)) buf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (hbuf_we),
    .host_widx (hbuf_widx),
    .host_wdata(reg_wdata),
    .host_ridx (hbuf_ridx),
    .host_rdata(hbuf_rdata),
    .sh_rpos   (sbuf_rpos),
    .sh_rbit   (sbuf_rbit),
    .sh_we     (sbuf_we),
    .sh_wpos   (sbuf_wpos),
    .sh_wbit   (sbuf_wbit)
  );

  spifc_shifter #(.BUF_BYTES(BUF_BYTES)) shift_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(srst_pulse),
    .start   (start_pulse),
    .len_m1  (cfg_len),
    .rx_en   (cfg_rx),
    .cs_hold (cfg_hold),
    .rise_en (sck_rise_en),
    .fall_en (sck_fall_en),
    .miso    (spi_miso),
    .rd_pos  (sbuf_rpos),
    .rd_bit  (sbuf_rbit),
    .wr_en   (sbuf_we),
    .wr_pos  (sbuf_wpos),
    .wr_bit  (sbuf_wbit),
    .sck     (spi_sck),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .busy    (eng_busy),
    .done_set(done_set)
  );
endmodule

// File: rtl/spifc_engine_chk.sv
module spifc_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic mosi,
  input logic rise_en,
  input logic busy,
  input logic done,
  input logic soft_rst
);
  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R5
  sck_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $past(rise_en));

  // R3
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  // R4
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  // R8
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cs_n && !sck && !busy && !done));
endmodule

bind spifc_engine spifc_engine_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .sck     (spi_sck),
  .cs_n    (spi_cs_n),
  .mosi    (spi_mosi),
  .rise_en (sck_rise_en),
  .busy    (eng_busy),
  .done    (done_flag),
  .soft_rst(srst_pulse)
);

// File: tb/spifc_engine_tb_top.sv
`timescale 1ns/100ps
module spifc_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck_rise_en, sck_fall_en;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  // edge strobes: one rise and one fall per four cycles
  logic [1:0] ph = '0;
  always @(posedge clk) ph <= ph + 2'd1;
  assign sck_rise_en = (ph == 2'd1);
  assign sck_fall_en = (ph == 2'd3);

  spifc_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // slave model
  int         sidx = 0;
  int         cyc = 0;
  int         cs_fall_cyc = 0;
  int         first_rise_cyc = 0;
  int         cs_rises = 0;
  logic [7:0] cap [64];
  logic [7:0] resp_seed = '0;
  logic [7:0] rb;

  function automatic logic [7:0] resp_byte(int j);
    return 8'(j * 29) ^ resp_seed;
  endfunction

  function automatic logic [7:0] tx_byte(int j, logic [7:0] seed);
    return 8'(j * 13) + seed;
  endfunction

  always @(posedge clk) cyc++;
  always @(negedge spi_cs_n) cs_fall_cyc = cyc;
  always @(posedge spi_cs_n) cs_rises++;
  always @(posedge spi_sck) begin
    if (sidx == 0) first_rise_cyc = cyc;
    if (sidx < 512) cap[sidx / 8][7 - (sidx % 8)] = spi_mosi;
    sidx++;
  end
  always_comb begin
    rb = resp_byte(sidx / 8);
    spi_miso = (sidx < 512) ? rb[7 - (sidx % 8)] : 1'b0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic prep(int n, bit rx, bit hold, logic [7:0] seed);
    for (int w = 0; w < 16; w++)
      wr(7'(8'h40 + 4 * w), {tx_byte(4*w+3, seed), tx_byte(4*w+2, seed),
                             tx_byte(4*w+1, seed), tx_byte(4*w, seed)});
    resp_seed = seed + 8'd1;
    wr(7'h30, 32'h0);
    wr(7'h20, 32'(8 * n - 1) << 17);
    wr(7'h1C, {31'b0, rx});
    wr(7'h2C, {1'b0, hold, 30'b0});
    sidx = 0;
  endtask

  task automatic go();
    wr(7'h00, 32'h0004_0000);
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    bit idle = 0;
    for (int i = 0; i < 10000 && !idle; i++) begin
      rd(7'h00, d);
      idle = !d[18];
    end
    check("R3 busy clears", {31'b0, idle}, 32'h1);
  endtask

  task automatic post_checks(int n, bit rx, bit hold, logic [7:0] seed,
                             int rises_before);
    logic [31:0] d;
    int mism;
    check("R2 edge count", 32'(sidx), 32'(8 * n));
    mism = 0;
    for (int j = 0; j < n; j++) if (cap[j] !== tx_byte(j, seed)) mism++;
    check("R5 msb-first mosi bytes", 32'(mism), 32'h0);
    mism = 0;
    for (int w = 0; w < 16; w++) begin
      rd(7'(8'h40 + 4 * w), d);
      for (int b = 0; b < 4; b++) begin
        int j = 4 * w + b;
        logic [7:0] e = (j < n && rx) ? resp_byte(j) : tx_byte(j, seed);
        if (d[8*b +: 8] !== e) mism++;
      end
    end
    check(rx ? "R6 rx overwrite R1" : "R6 buffer kept R1", 32'(mism), 32'h0);
    check("R7 cs level", {31'b0, spi_cs_n}, {31'b0, !hold});
    check("R7 cs releases", 32'(cs_rises - rises_before), hold ? 32'h0 : 32'h1);
    rd(7'h30, d);
    check("R4 done set", d, 32'h10);
  endtask

  // vector table: {bytes, flags(bit1 rx, bit0 hold), seed}
  localparam int N_VEC = 5;
  localparam logic [23:0] VEC [N_VEC] = '{
    24'h04_02_11, 24'h01_03_22, 24'h03_01_33, 24'h40_02_44, 24'h07_00_55
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit prev_hold;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 cs_n", {31'b0, spi_cs_n}, 32'h1);
    check("R12 sck", {31'b0, spi_sck}, 32'h0);
    check("R12 mosi", {31'b0, spi_mosi}, 32'h0);
    rd(7'h00, d); check("R12 cmd", d, 32'h0);
    rd(7'h20, d); check("R12 len", d, 32'h0);
    rd(7'h30, d); check("R12 stat", d, 32'h0);
    rd(7'h7C, d); check("R12 buffer", d, 32'h0);

    prev_hold = 0;
    for (int v = 0; v < N_VEC; v++) begin
      int n = int'(VEC[v][23:16]);
      bit rx = VEC[v][9];
      bit hold = VEC[v][8];
      logic [7:0] seed = VEC[v][7:0];
      int rb0;
      prep(n, rx, hold, seed);
      rb0 = cs_rises;
      go();
      wait_idle();
      post_checks(n, rx, hold, seed, rb0);
      if (!prev_hold)
        check("R11 cs setup", {31'b0, (first_rise_cyc - cs_fall_cyc) >= 2}, 32'h1);
      prev_hold = hold;
    end

    // R4 writing 0 clears done
    wr(7'h30, 32'h0);
    rd(7'h30, d); check("R4 done cleared", d, 32'h0);

    // R9 / R10: start, length change and buffer write while busy
    prep(8, 1, 0, 8'h66);
    go();
    repeat (20) @(negedge clk);
    wr(7'h00, 32'h0004_0000);
    wr(7'h20, 32'(16 * 8 - 1) << 17);
    wr(7'h44, 32'hFFFF_FFFF);
    wait_idle();
    check("R9 R10 bit count kept", 32'(sidx), 32'(64));
    check("R10 shifted byte 4", {24'b0, cap[4]}, {24'b0, tx_byte(4, 8'h66)});
    check("R10 shifted byte 7", {24'b0, cap[7]}, {24'b0, tx_byte(7, 8'h66)});
    rd(7'h44, d);
    check("R10 word1 holds rx", d, {resp_byte(7), resp_byte(6), resp_byte(5), resp_byte(4)});
    rd(7'h20, d);
    check("R10 len reg updated", d, 32'(127) << 17);

    // R8 soft reset in the middle of a held transfer
    prep(16, 1, 1, 8'h77);
    go();
    repeat (40) @(negedge clk);
    wr(7'h30, 32'h8000_0000);
    check("R8 cs released", {31'b0, spi_cs_n}, 32'h1);
    check("R8 sck low", {31'b0, spi_sck}, 32'h0);
    rd(7'h00, d); check("R8 not busy", d, 32'h0);
    rd(7'h30, d); check("R8 stat reads 0", d, 32'h0);

    // recovery after soft reset
    begin
      int rb0;
      prep(2, 1, 0, 8'h88);
      rb0 = cs_rises;
      go();
      wait_idle();
      post_checks(2, 1, 0, 8'h88, rb0);
      check("R11 setup after soft reset", {31'b0, (first_rise_cyc - cs_fall_cyc) >= 2}, 32'h1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule